// File: doc/BRIEF.md
# Indirect Register Access Engine

This block lets a host with a byte-wide register port reach a large internal register space that is too wide to map directly. The host fills a four-byte data window and a two-byte target address through its byte port. It then writes the control byte, which starts an indirect read or write on a simple request/acknowledge internal register bus. A busy flag in the control byte stays set while the access runs. When the access finishes, a 6-bit completion code is left in the same byte.

Before any bus cycle is issued, the engine checks the target. The checks cover an address outside the defined space, a write to a protected register, and a second write to a write-once register since reset. A slave that never acknowledges is caught by a fixed cycle timeout. Every failure ends with its own code, so the host can tell these causes apart. A successful read loads the whole window at the same clock edge on which busy clears.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control byte (offset 0), the four window bytes (offsets 1 to 4) and the two address bytes (offsets 5 and 6) all read 0, and no internal request is active.
- R2: The control byte holds the completion code in bits 5:0, the direction in bit 6 and busy in bit 7. A host write to offset 0 while idle starts an access: bit 6 of the written byte selects the direction (1 read, 0 write), and the code is cleared to 0.
- R3: Busy reads 1 from the clock edge that takes the starting write. It stays 1 until completion. An access rejected by the target checks completes one cycle after the start. A bus access completes on the edge that follows an acknowledge seen after L wait cycles, so busy is high for 2+L cycles.
- R4: A successful write drives ib_we high and presents the target address from offsets 5 (low byte) and 6 (high byte). The data comes from the window, where offset 1 is bits 7:0 and offset 4 is bits 31:24. The access ends with code 0.
- R5: A successful read ends with code 0. All four window bytes take the returned word at the edge on which busy clears.
- R6: An access in either direction to an address at or above NUM_REGS (64) ends with code 7 and issues no internal request.
- R7: A write to a protected address (PROT_BASE 56 up to NUM_REGS-1) ends with code 0x3E and issues no internal request. Reads of those addresses proceed normally.
- R8: Each write-once address (WO_BASE 16 up to WO_BASE+WO_COUNT-1, i.e. 16 to 23) accepts one successful write after reset. Any later write to it ends with code 1 and issues no internal request. Reads are not affected, and reset re-arms the address.
- R9: If no acknowledge arrives within TIMEOUT (256) request cycles, the request drops, busy clears, the code is 0x3F, and the window keeps its previous contents.
- R10: Any host write while busy is ignored. The control byte, window and address keep their values, and no further access is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host register access strobe |
| host_we | input | 1 | Host write enable (with host_sel) |
| host_ofs | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for host_ofs (combinational) |
| ib_req | output | 1 | Internal bus request, held until acknowledge or timeout |
| ib_we | output | 1 | Internal bus direction, 1 for write |
| ib_addr | output | 16 | Internal bus register address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_rdata | input | 32 | Internal bus read data, valid with ib_ack |
| ib_ack | input | 1 | Internal bus acknowledge, one cycle |

## Verification
A sequencer stuck in its check or bus state shows up at once as a busy bit that does not fall within 2+L cycles, or as a request counted where none was due. A lost or stale write-once flag shows up on the very next write to that address, as code 0 where 1 was due or the reverse. A window loaded at the wrong moment or with the wrong bytes is read back right after busy clears, as do address or control bytes disturbed by writes that should have been ignored during busy.

// File: rtl/ind_bridge_pkg.sv
// Shared types and constants for the indirect register access engine.
package ind_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BUS   = 2'd2
    } seq_state_t;

    localparam logic [5:0] CODE_OK         = 6'd0;
    localparam logic [5:0] CODE_WRITE_ONCE = 6'd1;
    localparam logic [5:0] CODE_UNDEF      = 6'd7;
    localparam logic [5:0] CODE_PROTECTED  = 6'h3E;
    localparam logic [5:0] CODE_TIMEOUT    = 6'h3F;

    localparam int WIN_BYTES = 4;

    localparam logic [2:0] OFS_CTRL    = 3'd0;
    localparam logic [2:0] OFS_ADDR_LO = 3'd5;
    localparam logic [2:0] OFS_ADDR_HI = 3'd6;

endpackage

// File: rtl/ind_host_regs.sv
// Host-facing byte registers: control byte, data window and target address.
// Assumes: host writes take effect on the clock edge with host_sel && host_we;
// all writes are dropped while busy; AW is between 9 and 16.
module ind_host_regs
    import ind_bridge_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_we,
    input  logic [2:0]              host_ofs,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    input  logic                    busy,
    input  logic                    done,
    input  logic [5:0]              done_code,
    input  logic                    rd_load,
    input  logic [8*WIN_BYTES-1:0]  rd_data,
    output logic                    start,
    output logic                    rnw,
    output logic [AW-1:0]           tgt_addr,
    output logic [8*WIN_BYTES-1:0]  win_data
);

    logic                           wr_ok;
    logic                           rnw_q;
    logic [5:0]                     code_q;
    logic [15:0]                    addr_q;
    logic [WIN_BYTES-1:0][7:0]      win_q;

    assign wr_ok = host_sel && host_we && !busy;
    assign start = wr_ok && (host_ofs == OFS_CTRL);

    // Control fields: direction latched on start, code cleared on start, set on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnw_q  <= 1'b0;
            code_q <= CODE_OK;
        end else if (start) begin
            rnw_q  <= host_wdata[6];
            code_q <= CODE_OK;
        end else if (done) begin
            code_q <= done_code;
        end
    end

    // Target address bytes, written by the host only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_ok && host_ofs == OFS_ADDR_LO) begin
            addr_q[7:0] <= host_wdata;
        end else if (wr_ok && host_ofs == OFS_ADDR_HI) begin
            addr_q[15:8] <= host_wdata;
        end
    end

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_win
        localparam logic [2:0] BYTE_OFS = 3'(1 + b);
        // Window byte: whole-word load on read completion, else host byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[b] <= '0;
            end else if (rd_load) begin
                win_q[b] <= rd_data[8*b +: 8];
            end else if (wr_ok && host_ofs == BYTE_OFS) begin
                win_q[b] <= host_wdata;
            end
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = 8'h00;
        if (host_ofs == OFS_CTRL) begin
            host_rdata = {busy, rnw_q, code_q};
        end else if (host_ofs == OFS_ADDR_LO) begin
            host_rdata = addr_q[7:0];
        end else if (host_ofs == OFS_ADDR_HI) begin
            host_rdata = addr_q[15:8];
        end else begin
            for (int b = 0; b < WIN_BYTES; b++) begin
                if (host_ofs == 3'(1 + b)) host_rdata = win_q[b];
            end
        end
    end

    assign rnw      = rnw_q;
    assign tgt_addr = addr_q[AW-1:0];
    assign win_data = win_q;

    assert_ctrl_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && busy && !done) |=> ($stable(rnw_q) && $stable(code_q)));
    assert_addr_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && busy) |=> $stable(addr_q));
    assert_load_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> busy);

endmodule

// File: rtl/ind_access_check.sv
// Target checks run before any bus cycle: defined range, protected writes,
// and write-once tracking. Assumes the address is stable from start to done.
module ind_access_check
    import ind_bridge_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NUM_REGS  = 64,
    parameter int PROT_BASE = 56,
    parameter int WO_BASE   = 16,
    parameter int WO_COUNT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rnw,
    input  logic          wo_commit,
    output logic [5:0]    chk_code
);

    localparam logic [AW-1:0] NUM_A  = AW'(NUM_REGS);
    localparam logic [AW-1:0] PROT_A = AW'(PROT_BASE);

    logic [WO_COUNT-1:0] wo_match;
    logic [WO_COUNT-1:0] wo_done_q;
    logic                in_range;
    logic                is_prot;
    logic                wo_hit;

    for (genvar i = 0; i < WO_COUNT; i++) begin : g_wo
        localparam logic [AW-1:0] MY_ADDR = AW'(WO_BASE + i);
        assign wo_match[i] = (addr == MY_ADDR);
        // Write-once flag: set by a completed write, cleared only by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wo_done_q[i] <= 1'b0;
            end else if (wo_commit && wo_match[i]) begin
                wo_done_q[i] <= 1'b1;
            end
        end
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wo_done_q[i] |=> wo_done_q[i]);
    end

    assign in_range = (addr < NUM_A);
    assign is_prot  = (addr >= PROT_A);
    assign wo_hit   = |(wo_match & wo_done_q);

    // Code selection, in priority order: range, protection, write-once.
    always_comb begin
        if (!in_range) begin
            chk_code = CODE_UNDEF;
        end else if (!rnw && is_prot) begin
            chk_code = CODE_PROTECTED;
        end else if (!rnw && wo_hit) begin
            chk_code = CODE_WRITE_ONCE;
        end else begin
            chk_code = CODE_OK;
        end
    end

    assert_wo_code_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_code == CODE_WRITE_ONCE) |-> !rnw);

endmodule

// File: rtl/ind_bus_seq.sv
// Access sequencer: one check cycle, then a held request until acknowledge
// or TIMEOUT request cycles. Assumes ib_ack is only asserted during ib_req.
module ind_bus_seq
    import ind_bridge_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rnw,
    input  logic [5:0] chk_code,
    input  logic       ib_ack,
    output logic       busy,
    output logic       ib_req,
    output logic       done,
    output logic [5:0] done_code,
    output logic       rd_load,
    output logic       wo_commit
);

    localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    seq_state_t    state_q;
    logic [TW-1:0] cnt_q;
    logic          in_check;
    logic          in_bus;
    logic          expired;

    assign in_check = (state_q == ST_CHECK);
    assign in_bus   = (state_q == ST_BUS);
    assign expired  = in_bus && !ib_ack && (cnt_q == LAST);

    assign busy      = (state_q != ST_IDLE);
    assign ib_req    = in_bus;
    assign done      = (in_check && chk_code != CODE_OK) || (in_bus && (ib_ack || expired));
    assign done_code = in_check ? chk_code : (ib_ack ? CODE_OK : CODE_TIMEOUT);
    assign rd_load   = in_bus && ib_ack && rnw;
    assign wo_commit = in_bus && ib_ack && !rnw;

    // State register: idle -> check -> bus -> idle, with early exit on a check failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_CHECK;
                ST_CHECK: state_q <= (chk_code != CODE_OK) ? ST_IDLE : ST_BUS;
                ST_BUS:   if (done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Wait counter: counts request cycles without acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_check) begin
            cnt_q <= '0;
        end else if (in_bus && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_busy_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    assert_timeout_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && cnt_q == LAST) |=> !ib_req);

endmodule

// File: rtl/ind_reg_bridge.sv
// Top of the indirect register access engine: host byte registers, target
// checks and the internal bus sequencer. Assumes a single internal slave
// that answers each request with one ib_ack cycle.
module ind_reg_bridge
    import ind_bridge_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NUM_REGS  = 64,
    parameter int PROT_BASE = 56,
    parameter int WO_BASE   = 16,
    parameter int WO_COUNT  = 8,
    parameter int TIMEOUT   = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_we,
    input  logic [2:0]              host_ofs,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic                    ib_req,
    output logic                    ib_we,
    output logic [AW-1:0]           ib_addr,
    output logic [8*WIN_BYTES-1:0]  ib_wdata,
    input  logic [8*WIN_BYTES-1:0]  ib_rdata,
    input  logic                    ib_ack
);

    logic          busy;
    logic          done;
    logic [5:0]    done_code;
    logic          rd_load;
    logic          wo_commit;
    logic          start;
    logic          rnw;
    logic [5:0]    chk_code;

    ind_host_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_ofs   (host_ofs),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .done_code  (done_code),
        .rd_load    (rd_load),
        .rd_data    (ib_rdata),
        .start      (start),
        .rnw        (rnw),
        .tgt_addr   (ib_addr),
        .win_data   (ib_wdata)
    );

    ind_access_check #(
        .AW        (AW),
        .NUM_REGS  (NUM_REGS),
        .PROT_BASE (PROT_BASE),
        .WO_BASE   (WO_BASE),
        .WO_COUNT  (WO_COUNT)
    ) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (ib_addr),
        .rnw       (rnw),
        .wo_commit (wo_commit),
        .chk_code  (chk_code)
    );

    ind_bus_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rnw       (rnw),
        .chk_code  (chk_code),
        .ib_ack    (ib_ack),
        .busy      (busy),
        .ib_req    (ib_req),
        .done      (done),
        .done_code (done_code),
        .rd_load   (rd_load),
        .wo_commit (wo_commit)
    );

    assign ib_we = !rnw;

    assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && busy) |=> ($stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));
    assert_no_req_when_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ib_req) |-> (ib_addr < AW'(NUM_REGS)));

endmodule

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_ofs = 3'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        ib_req;
    logic        ib_we;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata;
    logic        ib_ack;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] slv_mem [64];
    logic [31:0] exp_mem [64];
    bit          wo_written [8];
    int          lat_cfg = 0;
    bit          hang = 0;
    int          wcnt = 0;
    int          req_seen = 0;
    bit          prev_req = 0;

    always #10 clk = ~clk;

    ind_reg_bridge u_ind_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ack(ib_ack)
    );

    // Internal bus slave model, driven on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ib_ack = 1'b0;
            ib_rdata = 32'd0;
            wcnt = 0;
        end else if (ib_ack) begin
            ib_ack = 1'b0;
        end else if (ib_req) begin
            if (!prev_req) req_seen++;
            if (!hang) begin
                if (wcnt >= lat_cfg) begin
                    ib_ack = 1'b1;
                    wcnt = 0;
                    if (ib_addr < 16'd64) begin
                        if (ib_we) slv_mem[ib_addr[5:0]] = ib_wdata;
                        else ib_rdata = slv_mem[ib_addr[5:0]];
                    end
                end else begin
                    wcnt++;
                end
            end
        end
        prev_req = ib_req;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_ofs = o; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] o, output logic [7:0] d);
        host_ofs = o;
        #1;
        d = host_rdata;
    endtask

    task automatic read_win(output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            hr(3'(1 + i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic start_acc(input logic [15:0] a, input bit rd, input logic [31:0] wd);
        for (int i = 0; i < 4; i++) hw(3'(1 + i), wd[8*i +: 8]);
        hw(3'd5, a[7:0]);
        hw(3'd6, a[15:8]);
        hw(3'd0, {1'b0, rd, 6'd0});
    endtask

    task automatic wait_done(output logic [7:0] ctrl, output int nb);
        nb = 0;
        hr(3'd0, ctrl);
        while (ctrl[7] && nb < 2000) begin
            nb++;
            @(negedge clk);
            hr(3'd0, ctrl);
        end
    endtask

    function automatic logic [5:0] exp_code(input logic [15:0] a, input bit rd);
        if (a >= 16'd64) return 6'd7;
        if (!rd && a >= 16'd56) return 6'h3E;
        if (!rd && a >= 16'd16 && a < 16'd24 && wo_written[a - 16'd16]) return 6'd1;
        return 6'd0;
    endfunction

    function automatic string tag_of(input logic [5:0] c, input bit rd);
        case (c)
            6'd0:    return rd ? "R5" : "R4";
            6'd7:    return "R6";
            6'h3E:   return "R7";
            6'd1:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run_acc(input logic [15:0] a, input bit rd, input logic [31:0] wd, input int lat);
        logic [5:0]  ec;
        logic [7:0]  ctrl;
        logic [31:0] w;
        int          nb;
        int          r0;
        string       tg;
        ec = exp_code(a, rd);
        if (hang && ec == 6'd0) ec = 6'h3F;
        tg = tag_of(ec, rd);
        lat_cfg = lat;
        r0 = req_seen;
        start_acc(a, rd, wd);
        wait_done(ctrl, nb);
        chk({tg, " R2 ctrl byte"}, {24'd0, ctrl}, {24'd0, 1'b0, rd, ec});
        if (ec == 6'd0) chk({tg, " R3 busy cycles"}, nb, 2 + lat);
        else if (ec != 6'h3F) chk({tg, " R3 busy cycles"}, nb, 1);
        else chk({tg, " R9 busy cycles"}, nb, 257);
        chk({tg, " request count"}, req_seen - r0, (ec == 6'd0 || ec == 6'h3F) ? 1 : 0);
        read_win(w);
        if (ec == 6'd0 && rd) chk({tg, " window"}, w, exp_mem[a[5:0]]);
        else chk({tg, " window"}, w, wd);
        if (ec == 6'd0 && !rd) begin
            exp_mem[a[5:0]] = wd;
            if (a >= 16'd16 && a < 16'd24) wo_written[a - 16'd16] = 1'b1;
            chk("R4 slave data", slv_mem[a[5:0]], wd);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) wo_written[i] = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0]  b;
        logic [7:0]  ctrl;
        logic [31:0] w;
        int          nb;
        int          r0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin
            slv_mem[i] = (32'(i) * 32'h01030507) ^ 32'hA5A5_0000;
            exp_mem[i] = slv_mem[i];
        end
        do_reset();

        // R1: reset state of every host register and of the request.
        for (int i = 0; i < 7; i++) begin
            hr(3'(i), b);
            chk("R1 reset register", {24'd0, b}, 32'd0);
        end
        chk("R1 reset request", {31'd0, ib_req}, 32'd0);

        // Directed: basic write, read back, latency variants.
        run_acc(16'd5, 1'b0, 32'hDEAD_BEEF, 0);
        run_acc(16'd5, 1'b1, 32'h1111_2222, 0);
        run_acc(16'd9, 1'b1, 32'h0, 3);
        // R6: undefined address both ways.
        run_acc(16'd64, 1'b1, 32'h3333_4444, 0);
        run_acc(16'h1234, 1'b0, 32'h5555_6666, 0);
        // R7: protected write rejected, read allowed.
        run_acc(16'd60, 1'b0, 32'h7777_8888, 0);
        run_acc(16'd60, 1'b1, 32'h0, 1);
        // R8: write-once address accepts one write.
        run_acc(16'd16, 1'b0, 32'hCAFE_0001, 0);
        run_acc(16'd16, 1'b0, 32'hCAFE_0002, 0);
        run_acc(16'd16, 1'b1, 32'h0, 0);

        // R10: host writes during busy are ignored.
        lat_cfg = 30;
        r0 = req_seen;
        start_acc(16'd7, 1'b1, 32'h0BAD_0BAD);
        hw(3'd0, 8'h00);
        hw(3'd1, 8'hFF);
        hw(3'd5, 8'h09);
        hr(3'd0, ctrl);
        chk("R10 R2 ctrl during busy", {24'd0, ctrl}, 32'h0000_00C0);
        hr(3'd5, b);
        chk("R10 address during busy", {24'd0, b}, 32'd7);
        wait_done(ctrl, nb);
        chk("R10 ctrl after", {24'd0, ctrl}, 32'h0000_0040);
        read_win(w);
        chk("R10 R5 window", w, exp_mem[7]);
        chk("R10 request count", req_seen - r0, 1);

        // R9: slave never acknowledges.
        hang = 1;
        run_acc(16'd3, 1'b1, 32'h4545_4545, 0);
        run_acc(16'd4, 1'b0, 32'h6767_6767, 0);
        hang = 0;
        exp_mem[4] = slv_mem[4];

        // Random mix with expectations from the bench model.
        for (int n = 0; n < 120; n++) begin
            int unsigned sel = $urandom_range(3, 0);
            logic [15:0] a;
            if (sel == 0) a = 16'($urandom_range(23, 16));
            else if (sel == 1) a = 16'($urandom_range(63, 54));
            else a = 16'($urandom_range(71, 0));
            run_acc(a, 1'($urandom_range(1, 0)), $urandom, int'($urandom_range(3, 0)));
        end

        // R8 and R1: reset re-arms the write-once flags.
        do_reset();
        hr(3'd0, b);
        chk("R1 ctrl after second reset", {24'd0, b}, 32'd0);
        run_acc(16'd16, 1'b0, 32'h0000_ABCD, 2);
        run_acc(16'd16, 1'b0, 32'h0000_DCBA, 0);

        summary();
    end

endmodule